// File: doc/BRIEF.md
# Segmented Circular Queue Pointer Manager

This block holds the read and write pointers for a set of output queues that share one 32K-entry message buffer. Software places each queue in the buffer with one 64-bit configuration word. The word gives a 5-bit region field for the upper address bits, a first chunk and a last chunk, each naming a 32-entry chunk, and an enable bit. A queue therefore spans 32 to 1024 entries in steps of 32 and never crosses a 1024-entry boundary.

A producer presents a push with a queue number and receives, one cycle later, either an accept pulse with the 15-bit buffer address to write, or an error pulse. A consumer does the same with a pop and receives the address to read. Each queue keeps an occupancy count. The block drives a registered empty flag and a registered full flag for every queue. The pointers step through the queue's chunks and wrap from the last entry of the last chunk to the first entry of the first chunk.

Top module: `seg_queue_ptr_mgr`

## Requirements
- R1: After a synchronous reset every queue is disabled, every empty flag is 1, every full flag is 0, and the response outputs are 0.
- R2: A configuration word takes its first chunk from bits [4:0], its last chunk from bits [9:5], its region from bits [14:10] and its enable from bit 63. On the edge that writes it, the queue's head and tail move to offset 0 of the first chunk and its count clears, so the next flags read empty=1 and full=0.
- R3: An accepted push gives push_ok=1 in the cycle after the request. push_addr is {region, tail chunk, tail offset}, and the tail then advances by one entry.
- R4: An accepted pop gives pop_ok=1 in the cycle after the request, with pop_addr equal to the head address, and the head then advances. Pops return addresses in the order the pushes wrote them.
- R5: A pointer at offset 31 of the last chunk moves next to offset 0 of the first chunk.
- R6: The full flag is 1 exactly when the count equals (last - first + 1) * 32. The empty flag is 1 exactly when the count is 0.
- R7: A push to a full queue gives push_err=1 and push_ok=0, and it changes neither pointer nor the count.
- R8: A pop from an empty queue gives pop_err=1 and pop_ok=0, and it changes no state.
- R9: A queue whose enable bit is 0, or whose last chunk is below its first chunk, rejects every push and pop with an error pulse.
- R10: A push and a pop accepted together on the same queue both take effect, and the count and flags are unchanged.
- R11: A push or pop aimed at a queue that is being configured in the same cycle is rejected with an error pulse.
- R12: Traffic on one queue leaves the pointers and flags of every other queue unchanged.
- R13: The ok and error pulses of a port are never 1 together, and neither is 1 unless that port made a request in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | QID_W | Queue being configured |
| cfg_data | input | 64 | Configuration word |
| push_vld | input | 1 | Push request |
| push_qid | input | QID_W | Queue to push |
| pop_vld | input | 1 | Pop request |
| pop_qid | input | QID_W | Queue to pop |
| push_ok | output | 1 | Push accepted (one cycle after request) |
| push_err | output | 1 | Push rejected |
| push_addr | output | 15 | Buffer address to write |
| pop_ok | output | 1 | Pop accepted |
| pop_err | output | 1 | Pop rejected |
| pop_addr | output | 15 | Buffer address to read |
| empty_vec | output | NUM_Q | Per-queue empty flags |
| full_vec | output | NUM_Q | Per-queue full flags |

## Verification
A corrupted tail or head pointer appears on the very next accepted push or pop of that queue as a wrong address. A wrong wrap shows up on the first access past the last chunk. A count that drifts shows on the flags one cycle after the request that caused it, or as an accept where an error pulse was due. Because of this, the tests follow every rejected or paired request with a push and a pop on the same queue and compare the addresses, and they check the flags of neighbouring queues while another queue is busy.

// File: rtl/seg_q_pkg.sv
package seg_q_pkg;
  localparam int OFF_W   = 5;
  localparam int CHUNK_W = 5;
  localparam int REG_W   = 5;
  localparam int LOC_W   = CHUNK_W + OFF_W;
  localparam int ADDR_W  = REG_W + LOC_W;
  localparam int CNT_W   = LOC_W + 1;
  localparam int CFG_W   = 64;
  localparam int EN_BIT  = 63;

  typedef struct packed {
    logic               en;
    logic [REG_W-1:0]   region;
    logic [CHUNK_W-1:0] last;
    logic [CHUNK_W-1:0] first;
  } q_cfg_t;

  // a region with last below first is kept disabled
  function automatic q_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    q_cfg_t c;
    c.first  = w[CHUNK_W-1:0];
    c.last   = w[2*CHUNK_W-1:CHUNK_W];
    c.region = w[2*CHUNK_W+REG_W-1:2*CHUNK_W];
    c.en     = w[EN_BIT] && (c.last >= c.first);
    return c;
  endfunction

  function automatic logic [LOC_W-1:0] step_ptr(input logic [LOC_W-1:0] p,
                                                input q_cfg_t c);
    if (p == {c.last, {OFF_W{1'b1}}})
      return {c.first, {OFF_W{1'b0}}};
    return p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] room(input q_cfg_t c);
    logic [CNT_W-1:0] n;
    n = CNT_W'(c.last) - CNT_W'(c.first) + 1'b1;
    return n << OFF_W;
  endfunction
endpackage

// File: rtl/sq_slot.sv
module sq_slot
  import seg_q_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             push_go,
  input  logic             pop_go,
  output logic             en,
  output logic [ADDR_W-1:0] head_addr,
  output logic [ADDR_W-1:0] tail_addr,
  output logic             empty,
  output logic             full
);
  q_cfg_t           cfg_q;
  q_cfg_t           cfg_new;
  logic [LOC_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign cfg_new = unpack_cfg(cfg_word);

  always_comb begin
    unique case ({push_go, pop_go})
      2'b10:   cnt_nxt = cnt_q + 1'b1;
      2'b01:   cnt_nxt = cnt_q - 1'b1;
      default: cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
    end else if (cfg_wr) begin
      cfg_q  <= cfg_new;
      head_q <= {cfg_new.first, {OFF_W{1'b0}}};
      tail_q <= {cfg_new.first, {OFF_W{1'b0}}};
      cnt_q  <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
    end else begin
      if (push_go) tail_q <= step_ptr(tail_q, cfg_q);
      if (pop_go)  head_q <= step_ptr(head_q, cfg_q);
      cnt_q <= cnt_nxt;
      empty <= (cnt_nxt == '0);
      full  <= cfg_q.en && (cnt_nxt == room(cfg_q));
    end
  end

  assign en        = cfg_q.en;
  assign head_addr = {cfg_q.region, head_q};
  assign tail_addr = {cfg_q.region, tail_q};
endmodule

// File: rtl/sq_req_gate.sv
module sq_req_gate #(
  parameter int NUM_Q = 16,
  localparam int QID_W = $clog2(NUM_Q)
)(
  input  logic             cfg_we,
  input  logic [QID_W-1:0] cfg_qid,
  input  logic             push_vld,
  input  logic [QID_W-1:0] push_qid,
  input  logic             pop_vld,
  input  logic [QID_W-1:0] pop_qid,
  input  logic [NUM_Q-1:0] en_vec,
  input  logic [NUM_Q-1:0] empty_vec,
  input  logic [NUM_Q-1:0] full_vec,
  output logic [NUM_Q-1:0] push_go,
  output logic [NUM_Q-1:0] pop_go,
  output logic             push_acc,
  output logic             pop_acc
);
  always_comb begin
    push_go  = '0;
    pop_go   = '0;
    push_acc = push_vld && en_vec[push_qid] && !full_vec[push_qid] &&
               !(cfg_we && (cfg_qid == push_qid));
    pop_acc  = pop_vld && en_vec[pop_qid] && !empty_vec[pop_qid] &&
               !(cfg_we && (cfg_qid == pop_qid));
    if (push_acc) push_go[push_qid] = 1'b1;
    if (pop_acc)  pop_go[pop_qid]   = 1'b1;
  end
endmodule

// File: rtl/sq_resp_reg.sv
module sq_resp_reg
  import seg_q_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic              acc,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              ok,
  output logic              err,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ok   <= 1'b0;
      err  <= 1'b0;
      addr <= '0;
    end else begin
      ok   <= acc;
      err  <= vld && !acc;
      addr <= acc ? addr_in : '0;
    end
  end
endmodule

// File: rtl/seg_queue_ptr_mgr.sv
module seg_queue_ptr_mgr
  import seg_q_pkg::*;
#(
  parameter int NUM_Q = 16,
  localparam int QID_W = $clog2(NUM_Q)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [QID_W-1:0]  cfg_qid,
  input  logic [63:0]       cfg_data,
  input  logic              push_vld,
  input  logic [QID_W-1:0]  push_qid,
  input  logic              pop_vld,
  input  logic [QID_W-1:0]  pop_qid,
  output logic              push_ok,
  output logic              push_err,
  output logic [14:0]       push_addr,
  output logic              pop_ok,
  output logic              pop_err,
  output logic [14:0]       pop_addr,
  output logic [NUM_Q-1:0]  empty_vec,
  output logic [NUM_Q-1:0]  full_vec
);
  logic [NUM_Q-1:0]  en_vec, push_go, pop_go;
  logic [ADDR_W-1:0] head_a [NUM_Q];
  logic [ADDR_W-1:0] tail_a [NUM_Q];
  logic              push_acc, pop_acc;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_slot
    sq_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .cfg_wr   (cfg_we && (cfg_qid == QID_W'(q))),
      .cfg_word (cfg_data),
      .push_go  (push_go[q]),
      .pop_go   (pop_go[q]),
      .en       (en_vec[q]),
      .head_addr(head_a[q]),
      .tail_addr(tail_a[q]),
      .empty    (empty_vec[q]),
      .full     (full_vec[q])
    );
  end

  sq_req_gate #(.NUM_Q(NUM_Q)) u_gate (
    .cfg_we   (cfg_we),
    .cfg_qid  (cfg_qid),
    .push_vld (push_vld),
    .push_qid (push_qid),
    .pop_vld  (pop_vld),
    .pop_qid  (pop_qid),
    .en_vec   (en_vec),
    .empty_vec(empty_vec),
    .full_vec (full_vec),
    .push_go  (push_go),
    .pop_go   (pop_go),
    .push_acc (push_acc),
    .pop_acc  (pop_acc)
  );

  sq_resp_reg u_push_resp (
    .clk(clk), .rst(rst), .vld(push_vld), .acc(push_acc),
    .addr_in(tail_a[push_qid]), .ok(push_ok), .err(push_err), .addr(push_addr)
  );

  sq_resp_reg u_pop_resp (
    .clk(clk), .rst(rst), .vld(pop_vld), .acc(pop_acc),
    .addr_in(head_a[pop_qid]), .ok(pop_ok), .err(pop_err), .addr(pop_addr)
  );
endmodule

// File: rtl/seg_queue_ptr_mgr_chk.sv
module seg_queue_ptr_mgr_chk #(
  parameter int NUM_Q = 16,
  localparam int QID_W = $clog2(NUM_Q)
)(
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [QID_W-1:0] cfg_qid,
  input logic             push_vld,
  input logic [QID_W-1:0] push_qid,
  input logic             pop_vld,
  input logic [QID_W-1:0] pop_qid,
  input logic             push_ok,
  input logic             push_err,
  input logic             pop_ok,
  input logic             pop_err,
  input logic [NUM_Q-1:0] empty_vec,
  input logic [NUM_Q-1:0] full_vec
);
  // R13
  push_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(push_ok && push_err));
  // R13
  pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pop_ok && pop_err));
  // R13
  push_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !push_vld |=> !push_ok && !push_err);
  // R13
  pop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pop_vld |=> !pop_ok && !pop_err);
  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (empty_vec & full_vec) == '0);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push_vld && full_vec[push_qid] |=> push_err);
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop_vld && empty_vec[pop_qid] |=> pop_err);
  // R11
  cfg_clash_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we && push_vld && (cfg_qid == push_qid) |=> push_err);
endmodule

bind seg_queue_ptr_mgr seg_queue_ptr_mgr_chk #(.NUM_Q(NUM_Q)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
  .push_vld(push_vld), .push_qid(push_qid), .pop_vld(pop_vld), .pop_qid(pop_qid),
  .push_ok(push_ok), .push_err(push_err), .pop_ok(pop_ok), .pop_err(pop_err),
  .empty_vec(empty_vec), .full_vec(full_vec)
);

// File: tb/tb_seg_queue_ptr_mgr.sv
module tb_seg_queue_ptr_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_qid = '0;
  logic [63:0] cfg_data = '0;
  logic push_vld = 1'b0, pop_vld = 1'b0;
  logic [3:0] push_qid = '0, pop_qid = '0;
  logic push_ok, push_err, pop_ok, pop_err;
  logic [14:0] push_addr, pop_addr;
  logic [NQ-1:0] empty_vec, full_vec;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model, built from the requirements
  logic [4:0] m_first [NQ], m_last [NQ], m_reg [NQ];
  logic       m_en [NQ];
  logic [9:0] m_head [NQ], m_tail [NQ];
  int         m_cnt [NQ];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_queue_ptr_mgr #(.NUM_Q(NQ)) dut (.*);

  task automatic check(input bit cond, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int cap(input int q);
    return (int'(m_last[q]) - int'(m_first[q]) + 1) * 32;
  endfunction

  function automatic logic [9:0] adv(input logic [9:0] p, input int q);
    if (p == {m_last[q], 5'h1f}) return {m_first[q], 5'h00};
    return p + 10'd1;
  endfunction

  task automatic check_flags(input int q, input string req);
    check(empty_vec[q] == (m_cnt[q] == 0), req, 32'(empty_vec[q]), 32'(m_cnt[q] == 0));
    check(full_vec[q] == (m_en[q] && m_cnt[q] == cap(q)), req,
          32'(full_vec[q]), 32'(m_en[q] && m_cnt[q] == cap(q)));
  endtask

  task automatic configure(input int q, input int first, input int last,
                           input int rg, input bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_qid = 4'(q);
    cfg_data = {en, 48'd0, 5'(rg), 5'(last), 5'(first)};
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_first[q] = 5'(first); m_last[q] = 5'(last); m_reg[q] = 5'(rg);
    m_en[q] = en && (last >= first);
    m_head[q] = {5'(first), 5'd0}; m_tail[q] = {5'(first), 5'd0}; m_cnt[q] = 0;
    check(empty_vec[q] == 1'b1 && full_vec[q] == 1'b0, "R2 config clears", 32'({empty_vec[q], full_vec[q]}), 32'h2);
  endtask

  // one cycle with optional push and pop; expectations from the model
  task automatic op(input bit pv, input int pq, input bit qv, input int qq,
                    input string req);
    bit exp_push, exp_pop;
    logic [14:0] ea_push, ea_pop;
    exp_push = pv && m_en[pq] && m_cnt[pq] < cap(pq);
    exp_pop  = qv && m_en[qq] && m_cnt[qq] > 0;
    ea_push  = {m_reg[pq], m_tail[pq]};
    ea_pop   = {m_reg[qq], m_head[qq]};
    @(negedge clk);
    push_vld = pv; push_qid = 4'(pq); pop_vld = qv; pop_qid = 4'(qq);
    @(posedge clk); #1;
    push_vld = 1'b0; pop_vld = 1'b0;
    if (exp_push) begin m_tail[pq] = adv(m_tail[pq], pq); m_cnt[pq]++; end
    if (exp_pop)  begin m_head[qq] = adv(m_head[qq], qq); m_cnt[qq]--; end
    if (pv) begin
      check(push_ok == exp_push && push_err == !exp_push, req,
            32'({push_ok, push_err}), 32'({exp_push, !exp_push}));
      if (exp_push) check(push_addr == ea_push, req, 32'(push_addr), 32'(ea_push));
      check_flags(pq, req);
    end
    if (qv) begin
      check(pop_ok == exp_pop && pop_err == !exp_pop, req,
            32'({pop_ok, pop_err}), 32'({exp_pop, !exp_pop}));
      if (exp_pop) check(pop_addr == ea_pop, req, 32'(pop_addr), 32'(ea_pop));
      check_flags(qq, req);
    end
  endtask

  task automatic t_reset;
    check(empty_vec == '1 && full_vec == '0, "R1 flags", 32'({empty_vec, full_vec}), 32'hffff0000);
    check(!push_ok && !push_err && !pop_ok && !pop_err && push_addr == 0 && pop_addr == 0,
          "R1 outputs", 32'({push_ok, push_err, pop_ok, pop_err}), 32'h0);
  endtask

  task automatic t_fill_wrap;
    configure(0, 2, 2, 3, 1'b1);
    for (int i = 0; i < 32; i++) op(1, 0, 0, 0, "R3 push fill");
    check(full_vec[0] == 1'b1, "R6 full at 32", 32'(full_vec[0]), 32'h1);
    op(1, 0, 0, 0, "R7 push on full");
    op(0, 0, 1, 0, "R4 pop first");
    op(1, 0, 0, 0, "R5 tail wraps to first chunk");
    for (int i = 0; i < 32; i++) op(0, 0, 1, 0, "R4 drain order");
    op(0, 0, 1, 0, "R8 pop on empty");
    op(1, 0, 0, 0, "R7 R8 state kept after rejects");
  endtask

  task automatic t_multi_chunk;
    configure(5, 30, 31, 31, 1'b1);
    for (int i = 0; i < 64; i++) op(1, 5, 0, 0, "R5 top of buffer");
    check(full_vec[5] == 1'b1 && empty_vec[5] == 1'b0, "R6 full at 64",
          32'({full_vec[5], empty_vec[5]}), 32'h2);
    op(0, 0, 1, 5, "R4 head from first chunk");
    op(1, 5, 1, 5, "R10 push and pop together");
    check(full_vec[5] == 1'b0, "R10 count unchanged", 32'(full_vec[5]), 32'h0);
  endtask

  task automatic t_disabled;
    configure(2, 0, 3, 1, 1'b0);
    op(1, 2, 1, 2, "R9 enable clear");
    configure(3, 7, 4, 1, 1'b1);
    op(1, 3, 1, 3, "R9 last below first");
  endtask

  task automatic t_pair_and_clash;
    configure(1, 0, 1, 0, 1'b1);
    op(1, 1, 0, 0, "R3 single push");
    op(1, 1, 1, 1, "R10 pair on one entry");
    check(empty_vec[1] == 1'b0, "R10 still one entry", 32'(empty_vec[1]), 32'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_qid = 4'd1; cfg_data = {1'b1, 48'd0, 5'd0, 5'd1, 5'd0};
    push_vld = 1'b1; push_qid = 4'd1;
    @(posedge clk); #1;
    cfg_we = 1'b0; push_vld = 1'b0;
    m_head[1] = 10'd0; m_tail[1] = 10'd0; m_cnt[1] = 0;
    check(push_err == 1'b1 && push_ok == 1'b0, "R11 clash rejected",
          32'({push_ok, push_err}), 32'h1);
    check(empty_vec[1] == 1'b1, "R11 R2 reset by config", 32'(empty_vec[1]), 32'h1);
    op(1, 1, 0, 0, "R11 next push at first chunk");
  endtask

  task automatic t_independent;
    configure(4, 10, 10, 9, 1'b1);
    for (int i = 0; i < 5; i++) op(1, 4, 0, 0, "R12 push other queue");
    check_flags(1, "R12 neighbour flags");
    check_flags(5, "R12 neighbour flags");
    op(1, 1, 1, 4, "R12 neighbour pointers");
    op(0, 0, 1, 1, "R12 neighbour pop");
  endtask

  initial begin
    for (int q = 0; q < NQ; q++) begin
      m_first[q] = 0; m_last[q] = 0; m_reg[q] = 0; m_en[q] = 0;
      m_head[q] = 0; m_tail[q] = 0; m_cnt[q] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    op(1, 6, 1, 6, "R9 R1 unconfigured queue");
    t_fill_wrap();
    t_multi_chunk();
    t_disabled();
    t_pair_and_clash();
    t_independent();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule